// File: doc/BRIEF.md
# Debug Request Mailbox Bridge

This block lets software that only issues simple register reads and writes drive a debug register channel. That channel uses valid/ready handshakes for both requests and responses. Software stages a target address and a write value in two request registers. It then writes an operation code, and that write launches one request on the outgoing channel. When the reply comes back, its data word and result code are latched into two read-only registers. A flags register tells software whether a new request may be launched and whether a reply is waiting. Any write to the flags register releases a waiting reply.

The block answers on a 32-byte window that starts at a parameterised base address. Reads are combinational from the address. Only one request can be outstanding at a time. The fields of the outgoing request are a snapshot taken when the launch is accepted. Software may therefore stage the next address and data while a request is still in flight. A read request needs only the address and the operation code, because the staged write value is carried along unchanged.

Top module: `dbg_mailbox_bridge`

## Requirements
- R1: After reset the flags register reads 0x1, every other register reads 0, and neither req_valid nor rsp_ready is asserted.
- R2: Word offsets from BASE_ADDR are: 0x00 request address, 0x04 request data, 0x08 operation (bits 1:0), 0x0C reply data, 0x10 reply code (bits 1:0) and 0x14 flags. Offsets 0x18 and 0x1C, addresses outside the window and addresses that are not word-aligned all read 0 and ignore writes.
- R3: A write to offset 0x08 while flag bit 0 is 1 raises req_valid on the next cycle. The request carries the staged address, the staged data and wdata[1:0] as the operation. Offset 0x08 reads back that operation code.
- R4: While req_valid is high and req_ready is low, req_valid stays high and the request fields do not change, even if the staging registers are rewritten. Rewritten staging values do read back.
- R5: Flag bit 0 is 1 only when the bridge is idle. It drops in the cycle after an accepted launch write and rises again only on acknowledgement. Flag bits 0 and 1 are never both 1.
- R6: rsp_ready is high only after the request handshake has completed and before a reply has been captured. It is never high while a reply is held.
- R7: When rsp_valid and rsp_ready are both high, rsp_data and rsp_op are captured into offsets 0x0C and 0x10, and flag bit 1 reads 1 from the next cycle on.
- R8: A write of any value to offset 0x14 while a reply is held clears flag bit 1 and sets flag bit 0 in the next cycle. Such a write at any other time has no effect.
- R9: A write to offset 0x08 while flag bit 0 is 0 starts no request and leaves both the operation readback and the driven request unchanged.
- R10: Flag bits 31:2 read as zero, and the reply code and operation readback are zero-extended.
- R11: The reply data and reply code registers keep their values through acknowledgement and through later launches, until the next reply is captured.
- R12: Writes to offsets 0x0C and 0x10 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address for a read or write |
| bus_wdata | input | DATA_W | Write value |
| bus_rdata | output | DATA_W | Combinational read value for bus_addr |
| req_valid | output | 1 | Outgoing request is valid |
| req_ready | input | 1 | Downstream accepts the request |
| req_addr | output | DATA_W | Request target register address |
| req_data | output | DATA_W | Request write value |
| req_op | output | OP_W | Request operation code |
| rsp_valid | input | 1 | Reply is valid |
| rsp_ready | output | 1 | Bridge can take a reply |
| rsp_data | input | DATA_W | Reply data word |
| rsp_op | input | OP_W | Reply result code |

## Verification
The bench holds req_ready low for several cycles and rewrites the staging registers during the stall. A bridge that forwards live register values instead of a snapshot would change the request in mid-handshake. It also writes a second launch while the bridge is busy and while a reply is held. A design that checks the wrong state would issue a duplicate request or overwrite the operation readback. The bench acknowledges while idle and while still waiting for a reply. A bridge that clears on any flags write would then report ready early and lose the reply. It also writes to the read-only reply registers, to addresses outside the window and to misaligned addresses. A decoder that aliases or ignores the low address bits would corrupt the state.

// File: rtl/mbx_pkg.sv
// Shared types for the debug request mailbox bridge.
// Assumes 32-bit word-aligned register slots in a 32-byte window.
package mbx_pkg;

    // Sequencer phase of the single outstanding request.
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_SEND = 2'd1,
        SQ_WAIT = 2'd2,
        SQ_HELD = 2'd3
    } seq_state_e;

    // Word slot index taken from address bits 4:2.
    typedef enum logic [2:0] {
        SLOT_REQ_ADDR = 3'd0,
        SLOT_REQ_DATA = 3'd1,
        SLOT_REQ_OP   = 3'd2,
        SLOT_RSP_DATA = 3'd3,
        SLOT_RSP_OP   = 3'd4,
        SLOT_FLAGS    = 3'd5
    } slot_e;

    localparam int unsigned WINDOW_LSB = 5;
    localparam int unsigned NUM_STAGE  = 2;

endpackage

// File: rtl/mbx_req_regs.sv
// Staging registers for the request address and the request data.
// Each is written whenever its strobe is high; there is no interlock with
// the sequencer, because the sequencer snapshots values at launch.
module mbx_req_regs #(
    parameter int unsigned DATA_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [mbx_pkg::NUM_STAGE-1:0]   wr_stb,
    input  logic [DATA_W-1:0]               wdata,
    output logic [DATA_W-1:0]               stage_addr,
    output logic [DATA_W-1:0]               stage_data
);
    logic [DATA_W-1:0] stage_q [mbx_pkg::NUM_STAGE];

    for (genvar g = 0; g < mbx_pkg::NUM_STAGE; g++) begin : g_stage
        // Load one staging word on its strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[g] <= '0;
            end else if (wr_stb[g]) begin
                stage_q[g] <= wdata;
            end
        end
    end

    assign stage_addr = stage_q[0];
    assign stage_data = stage_q[1];

endmodule

// File: rtl/mbx_seq.sv
// Request sequencer: idle -> send -> wait -> held -> idle.
// Launch is taken only when idle. The request fields are snapshotted at
// launch. The reply is accepted only in wait, and acknowledge is honoured
// only in held. Assumes at most one of launch_wr / ack_wr per cycle.
module mbx_seq #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned OP_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_wr,
    input  logic              ack_wr,
    input  logic [OP_W-1:0]   op_wdata,
    input  logic [DATA_W-1:0] stage_addr,
    input  logic [DATA_W-1:0] stage_data,
    input  logic              req_ready,
    input  logic              rsp_valid,
    output logic              req_valid,
    output logic [DATA_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic [OP_W-1:0]   req_op,
    output logic              rsp_ready,
    output logic              capture,
    output logic              st_ready,
    output logic              st_held
);
    import mbx_pkg::*;

    seq_state_e state_q, state_nx;
    logic       take_launch;

    assign take_launch = (state_q == SQ_IDLE) && launch_wr;

    // Next phase from the current phase and the handshakes.
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            SQ_IDLE: if (launch_wr) state_nx = SQ_SEND;
            SQ_SEND: if (req_ready) state_nx = SQ_WAIT;
            SQ_WAIT: if (rsp_valid) state_nx = SQ_HELD;
            SQ_HELD: if (ack_wr)    state_nx = SQ_IDLE;
            default: state_nx = SQ_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Snapshot of the request fields at an accepted launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_addr <= '0;
            req_data <= '0;
            req_op   <= '0;
        end else if (take_launch) begin
            req_addr <= stage_addr;
            req_data <= stage_data;
            req_op   <= op_wdata;
        end
    end

    assign req_valid = (state_q == SQ_SEND);
    assign rsp_ready = (state_q == SQ_WAIT);
    assign capture   = rsp_ready && rsp_valid;
    assign st_ready  = (state_q == SQ_IDLE);
    assign st_held   = (state_q == SQ_HELD);

endmodule

// File: rtl/mbx_rsp_hold.sv
// Reply holding registers. They load only on a capture pulse and keep
// their value otherwise; software cannot write them.
module mbx_rsp_hold #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned OP_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic [OP_W-1:0]   rsp_op,
    output logic [DATA_W-1:0] hold_data,
    output logic [OP_W-1:0]   hold_op
);
    // Latch the reply on the handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_data <= '0;
            hold_op   <= '0;
        end else if (capture) begin
            hold_data <= rsp_data;
            hold_op   <= rsp_op;
        end
    end

endmodule

// File: rtl/dbg_mailbox_bridge.sv
// Debug request mailbox bridge: a register window that launches one
// valid/ready request per operation write and holds the reply for polling.
// Assumes BASE_ADDR is aligned to the 32-byte window and that reads are
// side-effect free and combinational.
module dbg_mailbox_bridge #(
    parameter int unsigned      ADDR_W    = 32,
    parameter int unsigned      DATA_W    = 32,
    parameter int unsigned      OP_W      = 2,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h0003_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [DATA_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic [OP_W-1:0]   req_op,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic [OP_W-1:0]   rsp_op
);
    import mbx_pkg::*;

    localparam int unsigned PAD_OP   = DATA_W - OP_W;
    localparam int unsigned PAD_FLAG = DATA_W - 2;

    logic              win_hit;
    slot_e             slot;
    logic              wr_hit;
    logic [NUM_STAGE-1:0] stage_wr;
    logic              op_wr;
    logic              ack_wr;
    logic [DATA_W-1:0] stage_addr;
    logic [DATA_W-1:0] stage_data;
    logic              capture;
    logic              st_ready;
    logic              st_held;
    logic [DATA_W-1:0] rsp_data_q;
    logic [OP_W-1:0]   rsp_op_q;

    assign win_hit = (bus_addr[ADDR_W-1:WINDOW_LSB] == BASE_ADDR[ADDR_W-1:WINDOW_LSB])
                  && (bus_addr[1:0] == 2'b00);
    assign slot    = slot_e'(bus_addr[WINDOW_LSB-1:2]);
    assign wr_hit  = bus_wr_en && win_hit;

    // Write strobe decode per slot.
    always_comb begin
        stage_wr = '0;
        op_wr    = 1'b0;
        ack_wr   = 1'b0;
        if (wr_hit) begin
            unique case (slot)
                SLOT_REQ_ADDR: stage_wr[0] = 1'b1;
                SLOT_REQ_DATA: stage_wr[1] = 1'b1;
                SLOT_REQ_OP:   op_wr       = 1'b1;
                SLOT_FLAGS:    ack_wr      = 1'b1;
                default: ;
            endcase
        end
    end

    mbx_req_regs #(.DATA_W(DATA_W)) i_req_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (stage_wr),
        .wdata      (bus_wdata),
        .stage_addr (stage_addr),
        .stage_data (stage_data)
    );

    mbx_seq #(.DATA_W(DATA_W), .OP_W(OP_W)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch_wr  (op_wr),
        .ack_wr     (ack_wr),
        .op_wdata   (bus_wdata[OP_W-1:0]),
        .stage_addr (stage_addr),
        .stage_data (stage_data),
        .req_ready  (req_ready),
        .rsp_valid  (rsp_valid),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_data   (req_data),
        .req_op     (req_op),
        .rsp_ready  (rsp_ready),
        .capture    (capture),
        .st_ready   (st_ready),
        .st_held    (st_held)
    );

    mbx_rsp_hold #(.DATA_W(DATA_W), .OP_W(OP_W)) i_rsp_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .rsp_data  (rsp_data),
        .rsp_op    (rsp_op),
        .hold_data (rsp_data_q),
        .hold_op   (rsp_op_q)
    );

    // Read mux; unmapped slots and misses return zero.
    always_comb begin
        bus_rdata = '0;
        if (win_hit) begin
            unique case (slot)
                SLOT_REQ_ADDR: bus_rdata = stage_addr;
                SLOT_REQ_DATA: bus_rdata = stage_data;
                SLOT_REQ_OP:   bus_rdata = {{PAD_OP{1'b0}}, req_op};
                SLOT_RSP_DATA: bus_rdata = rsp_data_q;
                SLOT_RSP_OP:   bus_rdata = {{PAD_OP{1'b0}}, rsp_op_q};
                SLOT_FLAGS:    bus_rdata = {{PAD_FLAG{1'b0}}, st_held, st_ready};
                default:       bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/dbg_mailbox_bridge_checker.sv
// Protocol and state checks for the mailbox bridge, bound into the top.
// Observes ports plus the decoded strobes and the flag and reply state.
module dbg_mailbox_bridge_checker #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned OP_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [DATA_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_data,
    input logic [OP_W-1:0]   req_op,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [DATA_W-1:0] rsp_data,
    input logic [OP_W-1:0]   rsp_op,
    input logic              st_ready,
    input logic              st_held,
    input logic              op_wr,
    input logic              ack_wr,
    input logic [DATA_W-1:0] rsp_data_q,
    input logic [OP_W-1:0]   rsp_op_q
);
    AST_LAUNCH_RAISES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (st_ready && op_wr) |=> (req_valid && !st_ready)); // R3

    AST_REQ_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
                                       && $stable(req_data) && $stable(req_op))); // R4

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_ready && st_held)); // R5

    AST_RSP_READY_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |-> (!st_held && !st_ready && !req_valid)); // R6

    AST_CAPTURE_SETS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready) |=> (st_held && rsp_data_q == $past(rsp_data)
                                      && rsp_op_q == $past(rsp_op))); // R7

    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_held && ack_wr) |=> (st_ready && !st_held)); // R8

    AST_BUSY_LAUNCH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_ready && op_wr) |=> (!st_ready && $stable(req_op))); // R9

    AST_REPLY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && rsp_ready) |=> ($stable(rsp_data_q) && $stable(rsp_op_q))); // R11

endmodule

bind dbg_mailbox_bridge dbg_mailbox_bridge_checker #(
    .DATA_W (DATA_W),
    .OP_W   (OP_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_data   (req_data),
    .req_op     (req_op),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_data   (rsp_data),
    .rsp_op     (rsp_op),
    .st_ready   (st_ready),
    .st_held    (st_held),
    .op_wr      (op_wr),
    .ack_wr     (ack_wr),
    .rsp_data_q (rsp_data_q),
    .rsp_op_q   (rsp_op_q)
);

// File: tb/test_dbg_mailbox_bridge.sv
// Self-checking bench: a vector table of full request/reply exchanges,
// then directed tests for reset, decode and busy-state corner cases.
module test_dbg_mailbox_bridge;
    localparam logic [31:0] BASE = 32'h0003_1000;
    localparam logic [31:0] A_ADDR = BASE + 32'h00;
    localparam logic [31:0] A_DATA = BASE + 32'h04;
    localparam logic [31:0] A_OP   = BASE + 32'h08;
    localparam logic [31:0] A_RDAT = BASE + 32'h0C;
    localparam logic [31:0] A_ROP  = BASE + 32'h10;
    localparam logic [31:0] A_FLAG = BASE + 32'h14;

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] data;
        logic [1:0]  op;
        logic [3:0]  stall;
        logic [31:0] rdata;
        logic [1:0]  rop;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{addr: 32'h0000_0010, data: 32'h0000_0001, op: 2'd2, stall: 4'd0, rdata: 32'h0000_0000, rop: 2'd0},
        '{addr: 32'h0000_0011, data: 32'h0000_0001, op: 2'd1, stall: 4'd3, rdata: 32'hA5A5_0F0F, rop: 2'd0},
        '{addr: 32'h0000_0017, data: 32'h0010_100A, op: 2'd2, stall: 4'd1, rdata: 32'h1234_5678, rop: 2'd1},
        '{addr: 32'hFFFF_FFFF, data: 32'hDEAD_BEEF, op: 2'd3, stall: 4'd5, rdata: 32'hFFFF_FFFF, rop: 2'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [31:0] req_addr;
    logic [31:0] req_data;
    logic [1:0]  req_op;
    logic        rsp_valid = 1'b0;
    logic        rsp_ready;
    logic [31:0] rsp_data = '0;
    logic [1:0]  rsp_op = '0;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] rv;

    always #5 clk = ~clk;

    dbg_mailbox_bridge i_dbg_mailbox_bridge (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr_en (bus_wr_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .req_op    (req_op),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_data  (rsp_data),
        .rsp_op    (rsp_op)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic req_handshake();
        req_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_ready = 1'b0;
    endtask

    task automatic give_reply(input logic [31:0] d, input logic [1:0] o);
        rsp_valid = 1'b1;
        rsp_data  = d;
        rsp_op    = o;
        @(posedge clk);
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        bus_read(A_FLAG, rv); chk("R1", "flags after reset", rv, 32'h1);
        bus_read(A_ADDR, rv); chk("R1", "req addr after reset", rv, 32'h0);
        bus_read(A_RDAT, rv); chk("R1", "reply data after reset", rv, 32'h0);
        chk("R1", "req_valid after reset", {31'b0, req_valid}, 32'h0);
        chk("R1", "rsp_ready after reset", {31'b0, rsp_ready}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: full exchanges (R3 R4 R5 R6 R7 R8 R10 R11)
        foreach (VECS[i]) begin
            bus_write(A_ADDR, VECS[i].addr);
            bus_write(A_DATA, VECS[i].data);
            bus_read(A_ADDR, rv); chk("R2", "req addr readback", rv, VECS[i].addr);
            bus_write(A_OP, {30'b0, VECS[i].op});
            chk("R3", "req_valid after launch", {31'b0, req_valid}, 32'h1);
            chk("R3", "req_addr", req_addr, VECS[i].addr);
            chk("R3", "req_data", req_data, VECS[i].data);
            chk("R3", "req_op", {30'b0, req_op}, {30'b0, VECS[i].op});
            bus_read(A_OP, rv); chk("R3", "op readback", rv, {30'b0, VECS[i].op});
            bus_read(A_FLAG, rv); chk("R5", "flags while sending", rv, 32'h0);
            for (int s = 0; s < int'(VECS[i].stall); s++) begin
                @(negedge clk);
                chk("R4", "req_valid held in stall", {31'b0, req_valid}, 32'h1);
                chk("R4", "req_addr held in stall", req_addr, VECS[i].addr);
            end
            chk("R6", "rsp_ready before handshake", {31'b0, rsp_ready}, 32'h0);
            req_handshake();
            chk("R6", "rsp_ready while waiting", {31'b0, rsp_ready}, 32'h1);
            chk("R3", "req_valid after handshake", {31'b0, req_valid}, 32'h0);
            give_reply(VECS[i].rdata, VECS[i].rop);
            chk("R6", "rsp_ready while held", {31'b0, rsp_ready}, 32'h0);
            bus_read(A_FLAG, rv); chk("R7", "flags while held", rv, 32'h2);
            bus_read(A_RDAT, rv); chk("R7", "reply data", rv, VECS[i].rdata);
            bus_read(A_ROP, rv);  chk("R10", "reply code zero-extended", rv, {30'b0, VECS[i].rop});
            bus_write(A_FLAG, 32'hFFFF_FFFF);
            bus_read(A_FLAG, rv); chk("R8", "flags after ack", rv, 32'h1);
            bus_read(A_RDAT, rv); chk("R11", "reply data after ack", rv, VECS[i].rdata);
        end

        // R2: decode misses and unmapped slots
        bus_write(BASE + 32'h20, 32'h5555_5555);
        bus_write(BASE + 32'h01, 32'h6666_6666);
        bus_read(A_ADDR, rv); chk("R2", "req addr after miss writes", rv, VECS[3].addr);
        bus_read(BASE + 32'h18, rv); chk("R2", "unmapped slot", rv, 32'h0);
        bus_read(BASE + 32'h20, rv); chk("R2", "outside window", rv, 32'h0);
        bus_read(BASE + 32'h04 + 32'h2, rv); chk("R2", "misaligned read", rv, 32'h0);
        chk("R2", "no launch from miss", {31'b0, req_valid}, 32'h0);

        // R12: reply registers are read-only
        bus_write(A_RDAT, 32'h0BAD_0BAD);
        bus_write(A_ROP, 32'h1);
        bus_read(A_RDAT, rv); chk("R12", "reply data after write", rv, VECS[3].rdata);
        bus_read(A_ROP, rv);  chk("R12", "reply code after write", rv, {30'b0, VECS[3].rop});

        // R8: ack while idle has no effect
        bus_write(A_FLAG, 32'h3);
        bus_read(A_FLAG, rv); chk("R8", "ack while idle", rv, 32'h1);

        // Read request without writing data; R4 snapshot; R9 busy launch
        bus_write(A_ADDR, 32'h0000_0004);
        bus_write(A_OP, 32'h1);
        chk("R3", "read carries staged data", req_data, VECS[3].data);
        bus_write(A_ADDR, 32'h0000_0099);
        bus_write(A_DATA, 32'h0000_7777);
        chk("R4", "req_addr snapshot", req_addr, 32'h0000_0004);
        chk("R4", "req_data snapshot", req_data, VECS[3].data);
        bus_read(A_ADDR, rv); chk("R4", "staged addr readback", rv, 32'h0000_0099);
        bus_write(A_OP, 32'h2);
        chk("R9", "req_op during busy launch", {30'b0, req_op}, 32'h1);
        bus_read(A_OP, rv); chk("R9", "op readback after busy launch", rv, 32'h1);
        req_handshake();
        bus_write(A_FLAG, 32'h0);
        bus_read(A_FLAG, rv); chk("R8", "ack while waiting", rv, 32'h0);
        chk("R8", "rsp_ready kept after early ack", {31'b0, rsp_ready}, 32'h1);
        give_reply(32'hCAFE_F00D, 2'd1);
        bus_write(A_OP, 32'h3);
        chk("R9", "no request while held", {31'b0, req_valid}, 32'h0);
        bus_read(A_FLAG, rv); chk("R9", "flags unchanged while held", rv, 32'h2);
        bus_read(A_OP, rv); chk("R9", "op readback while held", rv, 32'h1);
        bus_write(A_FLAG, 32'h0);

        // R11: reply kept through a new launch
        bus_write(A_OP, 32'h2);
        bus_read(A_RDAT, rv); chk("R11", "reply data through launch", rv, 32'hCAFE_F00D);
        bus_read(A_ROP, rv);  chk("R11", "reply code through launch", rv, 32'h1);
        chk("R3", "relaunch uses new staging", req_addr, 32'h0000_0099);
        chk("R3", "relaunch data", req_data, 32'h0000_7777);

        summary();
    end

endmodule